// File: doc/BRIEF.md
# Activity-Reloaded Watchdog Timer

This block is a watchdog timer that software sets up through four byte-wide indexed registers: control, configuration, and the low and high bytes of a 16-bit count. Once a nonzero count is written, the counter counts down one step per time unit. The time unit is either one second or one minute, both derived by prescaling the block clock. A minute is sixty seconds.

There is no kick register. The counter is kept alive by activity pulses from neighbouring peripherals: a game-port access, a mouse interrupt, a keyboard interrupt, or a write to the infrared controller's data register. Each source has its own enable bit. The infrared source reloads only after a fixed settling delay.

When the counter runs out, or when software forces an expiry, a sticky status flag is set. Each enabled reset output then pulses for a fixed number of clocks, and an optional timeout level output follows the status flag. The counter then stays at zero until software writes the count again.

Top module: `actwd`

## Requirements
- R1: After a synchronous reset, every register reads zero, the counter is stopped, and `kbd_rst_o`, `pwr_rst_o` and `tmo_o` are low.
- R2: Index 0x71 is the control register. Bits 7, 6, 5 and 4 enable reload from infrared, mouse, keyboard and game-port activity. Bit 1 writes as a force strobe and reads as zero. Bit 0 is the status flag. Index 0x72 is the configuration register and reads back as written. Indices 0x73 and 0x74 read the live counter, low byte and high byte. Any other index reads zero, and writes to it change nothing.
- R3: A write to either count byte loads the counter with the updated 16-bit programmed value and restarts the prescaler. A value of zero stops the timer.
- R4: With configuration bit 7 set (seconds), the counter drops by one every CLKS_PER_SEC clocks. A count N written at clock edge w reaches zero at edge w + N*CLKS_PER_SEC.
- R5: With configuration bit 7 clear (minutes), the counter drops by one every 60*CLKS_PER_SEC clocks.
- R6: On reaching zero, the status flag (control bit 0) is set. The counter then holds zero, with no further ticks, until the count is written again.
- R7: On expiry, `kbd_rst_o` goes high for exactly RST_PULSE_CLKS clocks, starting after the expiry edge, if configuration bit 6 is set. `pwr_rst_o` does the same if configuration bit 4 is set. `tmo_o` is high while the status flag is set and configuration bit 5 is set.
- R8: A control write with bit 1 set forces an expiry at once, whether the timer is running or stopped. It clears the counter, sets the status flag and fires the enabled outputs.
- R9: A control write with bit 0 clear clears the status flag. Writing bit 0 as one never sets the flag and leaves it unchanged.
- R10: A game-port, mouse or keyboard pulse whose enable bit is set reloads a running counter to the programmed value and restarts the prescaler on the same edge. A pulse whose enable bit is clear has no effect.
- R11: An enabled infrared pulse reloads the counter IR_DELAY_CLKS edges after the edge that sampled it. Further infrared pulses while a reload is pending neither add a reload nor delay it.
- R12: Activity pulses have no effect while the counter is zero: a stopped or expired timer is not restarted by them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_idx | input | 8 | Register index, used for both write and read |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data for `reg_idx` |
| ev_ir | input | 1 | Infrared data-register write pulse |
| ev_mouse | input | 1 | Mouse interrupt pulse |
| ev_kbd | input | 1 | Keyboard interrupt pulse |
| ev_game | input | 1 | Game-port access pulse |
| kbd_rst_o | output | 1 | Keyboard-reset pulse on expiry |
| pwr_rst_o | output | 1 | Power-good reset pulse on expiry |
| tmo_o | output | 1 | Timeout level output |

## Verification
Several properties are checked on every cycle:
- an idle counter stays at zero;
- a running counter moves only by single steps on ticks;
- an expiry always leaves the status flag set, and the flag only rises after an expiry;
- every reset pulse starts from a trigger;
- the infrared delay line fires once per pending event.

The exact tick spacing in both time units can only be shown by the bench's timed sweeps. The same holds for the expiry edge for each count, the reload-to-expiry distance for each source, the infrared settling delay, and the pulse widths.

// File: rtl/actwd_pkg.sv
package actwd_pkg;

    localparam int REG_W        = 8;
    localparam int CNT_W        = 16;
    localparam int SECS_PER_MIN = 60;
    localparam int SEC_W        = $clog2(SECS_PER_MIN);
    localparam int NUM_SRC      = 4;

    localparam logic [REG_W-1:0] IDX_CTRL   = 8'h71;
    localparam logic [REG_W-1:0] IDX_CFG    = 8'h72;
    localparam logic [REG_W-1:0] IDX_CNT_LO = 8'h73;
    localparam logic [REG_W-1:0] IDX_CNT_HI = 8'h74;

    // source order equals control bit order 4..7
    localparam int SRC_GAME  = 0;
    localparam int SRC_KBD   = 1;
    localparam int SRC_MOUSE = 2;
    localparam int SRC_IR    = 3;

    localparam int CTRL_STATUS_BIT = 0;
    localparam int CTRL_FORCE_BIT  = 1;
    localparam int CTRL_EN_LSB     = 4;

    typedef struct packed {
        logic       sec_base;
        logic       kbd_rst_en;
        logic       tmo_en;
        logic       pwr_rst_en;
        logic [3:0] irq_line;
    } cfg_t;

    typedef struct packed {
        logic load;
        logic force_exp;
        logic reload;
        logic tick;
    } cnt_cmd_t;

    function automatic logic [REG_W-1:0] ctrl_view(input logic [NUM_SRC-1:0] en,
                                                   input logic st);
        return {en, 3'b000, st};
    endfunction

endpackage

// File: rtl/actwd_regs.sv
module actwd_regs
    import actwd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [REG_W-1:0] idx,
    input  logic [REG_W-1:0] wdata,
    input  logic             expire,
    input  logic [CNT_W-1:0] cnt,
    output logic [REG_W-1:0] rdata,
    output logic [NUM_SRC-1:0] src_en,
    output logic             unit_sec,
    output logic             kbd_en,
    output logic             pwr_en,
    output logic             tmo_en,
    output logic             status,
    output logic [CNT_W-1:0] preset,
    output logic [CNT_W-1:0] load_val,
    output logic             load,
    output logic             force_exp
);

    cfg_t cfg_q;
    logic wr_ctl, wr_cfg, wr_lo, wr_hi;

    assign wr_ctl = wr && (idx == IDX_CTRL);
    assign wr_cfg = wr && (idx == IDX_CFG);
    assign wr_lo  = wr && (idx == IDX_CNT_LO);
    assign wr_hi  = wr && (idx == IDX_CNT_HI);

    assign load      = wr_lo || wr_hi;
    assign force_exp = wr_ctl && wdata[CTRL_FORCE_BIT];

    always_comb begin
        load_val = preset;
        if (wr_lo) load_val[REG_W-1:0] = wdata;
        if (wr_hi) load_val[CNT_W-1:REG_W] = wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= '0;
            src_en <= '0;
            preset <= '0;
            status <= 1'b0;
        end else begin
            if (wr_ctl) src_en <= wdata[CTRL_EN_LSB +: NUM_SRC];
            if (wr_cfg) cfg_q  <= cfg_t'(wdata);
            if (load)   preset <= load_val;
            if (expire)
                status <= 1'b1;
            else if (wr_ctl && !wdata[CTRL_STATUS_BIT])
                status <= 1'b0;
        end
    end

    assign unit_sec = cfg_q.sec_base;
    assign kbd_en   = cfg_q.kbd_rst_en;
    assign pwr_en   = cfg_q.pwr_rst_en;
    assign tmo_en   = cfg_q.tmo_en;

    always_comb begin
        unique case (idx)
            IDX_CTRL:   rdata = ctrl_view(src_en, status);
            IDX_CFG:    rdata = cfg_q;
            IDX_CNT_LO: rdata = cnt[REG_W-1:0];
            IDX_CNT_HI: rdata = cnt[CNT_W-1:REG_W];
            default:    rdata = '0;
        endcase
    end

    AST_STATUS_AFTER_EXPIRY: assert property (@(posedge clk) disable iff (rst)
        expire |=> status); // R6
    AST_STATUS_RISE_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(status) |-> $past(expire)); // R9

endmodule

// File: rtl/actwd_tick.sv
module actwd_tick
    import actwd_pkg::*;
#(
    parameter int CLKS_PER_SEC = 50_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic unit_sec,
    output logic tick
);

    localparam int PRE_W = (CLKS_PER_SEC > 1) ? $clog2(CLKS_PER_SEC) : 1;

    logic [PRE_W-1:0] pre_q;
    logic [SEC_W-1:0] sec_q;
    logic             sec_tick, min_tick;

    assign sec_tick = (pre_q == PRE_W'(CLKS_PER_SEC - 1));
    assign min_tick = sec_tick && (sec_q == SEC_W'(SECS_PER_MIN - 1));
    assign tick     = unit_sec ? sec_tick : min_tick;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            pre_q <= '0;
            sec_q <= '0;
        end else if (sec_tick) begin
            pre_q <= '0;
            sec_q <= min_tick ? '0 : sec_q + 1'b1;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

    AST_SEC_RANGE: assert property (@(posedge clk) disable iff (rst)
        sec_q < SEC_W'(SECS_PER_MIN)); // R5

endmodule

// File: rtl/actwd_reload.sv
module actwd_reload
    import actwd_pkg::*;
#(
    parameter int IR_DELAY_CLKS = 250_000
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] ev,
    input  logic [NUM_SRC-1:0] src_en,
    output logic               reload
);

    logic [NUM_SRC-1:0] hit;
    logic               ir_fire;

    assign hit    = ev & src_en;
    assign reload = hit[SRC_GAME] || hit[SRC_KBD] || hit[SRC_MOUSE] || ir_fire;

    generate
        if (IR_DELAY_CLKS == 0) begin : g_ir_direct
            assign ir_fire = hit[SRC_IR];
        end else begin : g_ir_delay
            localparam int DW = (IR_DELAY_CLKS > 1) ? $clog2(IR_DELAY_CLKS) : 1;
            logic          pend;
            logic [DW-1:0] dcnt;

            assign ir_fire = pend && (dcnt == DW'(IR_DELAY_CLKS - 1));

            always_ff @(posedge clk) begin
                if (rst) begin
                    pend <= 1'b0;
                    dcnt <= '0;
                end else if (pend && !ir_fire) begin
                    dcnt <= dcnt + 1'b1;
                end else begin
                    pend <= hit[SRC_IR];
                    dcnt <= '0;
                end
            end

            AST_IR_ONE_SHOT: assert property (@(posedge clk) disable iff (rst)
                (ir_fire && !hit[SRC_IR]) |=> !ir_fire); // R11
            AST_IR_PEND_CAUSE: assert property (@(posedge clk) disable iff (rst)
                $rose(pend) |-> $past(hit[SRC_IR])); // R11
        end
    endgenerate

endmodule

// File: rtl/actwd_counter.sv
module actwd_counter
    import actwd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  cnt_cmd_t         cmd,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] preset,
    output logic [CNT_W-1:0] cnt,
    output logic             expire,
    output logic             restart
);

    logic running, reload_ok;

    assign running   = (cnt != '0);
    assign reload_ok = cmd.reload && running;
    assign restart   = cmd.load || reload_ok;
    assign expire    = !cmd.load &&
                       (cmd.force_exp ||
                        (!reload_ok && cmd.tick && cnt == CNT_W'(1)));

    always_ff @(posedge clk) begin
        if (rst)                 cnt <= '0;
        else if (cmd.load)       cnt <= load_val;
        else if (cmd.force_exp)  cnt <= '0;
        else if (reload_ok)      cnt <= preset;
        else if (cmd.tick && running) cnt <= cnt - 1'b1;
    end

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!running && !cmd.load) |=> (cnt == '0)); // R6
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
        (running && cmd.tick && !cmd.load && !cmd.force_exp && !cmd.reload)
        |=> (cnt == $past(cnt) - 1'b1)); // R4
    AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!cmd.tick && !cmd.load && !cmd.force_exp && !cmd.reload)
        |=> $stable(cnt)); // R4
    AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (rst)
        cmd.load |=> (cnt == $past(load_val))); // R3

endmodule

// File: rtl/actwd_pulse.sv
module actwd_pulse #(
    parameter int WIDTH_CLKS = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic trig,
    output logic pulse
);

    localparam int PW = $clog2(WIDTH_CLKS + 1);

    logic [PW-1:0] pcnt;

    assign pulse = (pcnt != '0);

    always_ff @(posedge clk) begin
        if (rst)        pcnt <= '0;
        else if (trig)  pcnt <= PW'(WIDTH_CLKS);
        else if (pulse) pcnt <= pcnt - 1'b1;
    end

    AST_PULSE_STARTS: assert property (@(posedge clk) disable iff (rst)
        trig |=> pulse); // R7
    AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(pulse) |-> $past(trig)); // R7

endmodule

// File: rtl/actwd.sv
module actwd
    import actwd_pkg::*;
#(
    parameter int CLKS_PER_SEC   = 50_000_000,
    parameter int IR_DELAY_CLKS  = 250_000,
    parameter int RST_PULSE_CLKS = 64
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       reg_wr,
    input  logic [7:0] reg_idx,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       ev_ir,
    input  logic       ev_mouse,
    input  logic       ev_kbd,
    input  logic       ev_game,
    output logic       kbd_rst_o,
    output logic       pwr_rst_o,
    output logic       tmo_o
);

    localparam int NUM_PULSE = 2;

    logic [NUM_SRC-1:0] ev_vec, src_en;
    logic [CNT_W-1:0]   cnt, preset, load_val;
    logic               unit_sec, kbd_en, pwr_en, tmo_en, status;
    logic               load, force_exp, reload, tick, expire, restart;
    cnt_cmd_t           cmd;
    logic [NUM_PULSE-1:0] p_en, p_out;

    assign ev_vec = {ev_ir, ev_mouse, ev_kbd, ev_game};

    actwd_regs u_regs (
        .clk(clk), .rst(rst), .wr(reg_wr), .idx(reg_idx), .wdata(reg_wdata),
        .expire(expire), .cnt(cnt), .rdata(reg_rdata), .src_en(src_en),
        .unit_sec(unit_sec), .kbd_en(kbd_en), .pwr_en(pwr_en), .tmo_en(tmo_en),
        .status(status), .preset(preset), .load_val(load_val),
        .load(load), .force_exp(force_exp)
    );

    actwd_tick #(.CLKS_PER_SEC(CLKS_PER_SEC)) u_tick (
        .clk(clk), .rst(rst), .restart(restart), .unit_sec(unit_sec), .tick(tick)
    );

    actwd_reload #(.IR_DELAY_CLKS(IR_DELAY_CLKS)) u_reload (
        .clk(clk), .rst(rst), .ev(ev_vec), .src_en(src_en), .reload(reload)
    );

    assign cmd = '{load: load, force_exp: force_exp, reload: reload, tick: tick};

    actwd_counter u_cnt (
        .clk(clk), .rst(rst), .cmd(cmd), .load_val(load_val), .preset(preset),
        .cnt(cnt), .expire(expire), .restart(restart)
    );

    assign p_en = {pwr_en, kbd_en};

    for (genvar g = 0; g < NUM_PULSE; g++) begin : g_pulse
        actwd_pulse #(.WIDTH_CLKS(RST_PULSE_CLKS)) u_pulse (
            .clk(clk), .rst(rst), .trig(expire && p_en[g]), .pulse(p_out[g])
        );
    end

    assign kbd_rst_o = p_out[0];
    assign pwr_rst_o = p_out[1];
    assign tmo_o     = status && tmo_en;

endmodule

// File: tb/actwd_tb_top.sv
module actwd_tb_top;

    localparam int C = 3;
    localparam int D = 5;
    localparam int P = 4;
    localparam logic [7:0] I_CTRL = 8'h71, I_CFG = 8'h72, I_LO = 8'h73, I_HI = 8'h74;

    logic       clk = 1'b0;
    logic       rst;
    logic       reg_wr;
    logic [7:0] reg_idx, reg_wdata;
    logic [7:0] reg_rdata;
    logic [3:0] ev;
    logic       kbd_rst_o, pwr_rst_o, tmo_o;
    int         checks = 0;
    int         fails = 0;
    bit         done = 1'b0;

    always #10 clk = ~clk;

    actwd #(.CLKS_PER_SEC(C), .IR_DELAY_CLKS(D), .RST_PULSE_CLKS(P)) dut_i (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_idx(reg_idx),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ev_ir(ev[3]), .ev_mouse(ev[2]), .ev_kbd(ev[1]), .ev_game(ev[0]),
        .kbd_rst_o(kbd_rst_o), .pwr_rst_o(pwr_rst_o), .tmo_o(tmo_o)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] idx, input logic [7:0] data);
        reg_wr = 1'b1; reg_idx = idx; reg_wdata = data;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] idx, output int v);
        reg_idx = idx;
        #1 v = int'(reg_rdata);
    endtask

    task automatic get_cnt(output int v);
        int lo, hi;
        rd(I_LO, lo);
        rd(I_HI, hi);
        v = hi * 256 + lo;
    endtask

    task automatic get_status(output int s);
        int c;
        rd(I_CTRL, c);
        s = c & 1;
    endtask

    task automatic pulse_ev(input int src);
        ev[src] = 1'b1;
        @(negedge clk);
        ev = '0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual 150000 cycles expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        int v, s;
        rst = 1'b1; reg_wr = 1'b0; reg_idx = '0; reg_wdata = '0; ev = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(I_CTRL, v); check("R1 ctrl", v, 0);
        rd(I_CFG, v);  check("R1 cfg", v, 0);
        get_cnt(v);    check("R1 count", v, 0);
        check("R1 kbd_rst_o", int'(kbd_rst_o), 0);
        check("R1 pwr_rst_o", int'(pwr_rst_o), 0);
        check("R1 tmo_o", int'(tmo_o), 0);

        // R2 register map
        wr(I_CFG, 8'hA5); rd(I_CFG, v); check("R2 cfg readback", v, 8'hA5);
        wr(8'h70, 8'hFF); rd(8'h70, v); check("R2 unmapped read", v, 0);
        rd(8'h75, v); check("R2 unmapped read", v, 0);
        rd(I_CFG, v); check("R2 unmapped write ignored", v, 8'hA5);
        wr(I_CTRL, 8'hF0); rd(I_CTRL, v); check("R2 ctrl readback", v, 8'hF0);

        // R3 R4 R6 R7 seconds sweep
        wr(I_CFG, 8'hC0);
        for (int n = 1; n <= 5; n++) begin
            wr(I_CTRL, 8'h00); wr(I_HI, 8'h00); wr(I_LO, 8'(n));
            for (int k = 0; k <= n * C; k++) begin
                get_cnt(v);    check("R4 seconds count", v, n - k / C);
                get_status(s); check("R6 status at expiry", s, (k == n * C) ? 1 : 0);
                if (k < n * C) step(1);
            end
            check("R7 kbd pulse start", int'(kbd_rst_o), 1);
            check("R7 pwr disabled", int'(pwr_rst_o), 0);
            for (int j = 1; j <= P + 1; j++) begin
                step(1);
                check("R7 kbd pulse width", int'(kbd_rst_o), (j < P) ? 1 : 0);
            end
            step(2 * C);
            get_cnt(v); check("R6 counter holds zero", v, 0);
        end

        // R3 sixteen-bit load
        wr(I_HI, 8'h12); wr(I_LO, 8'h34);
        get_cnt(v); check("R3 16-bit load", v, 16'h1234);
        wr(I_LO, 8'h00); wr(I_HI, 8'h00);
        step(3 * C); get_cnt(v); check("R3 zero stops", v, 0);

        // R5 minutes
        wr(I_CFG, 8'h40); wr(I_CTRL, 8'h00);
        wr(I_HI, 8'h00); wr(I_LO, 8'h02);
        for (int k = 0; k <= 2 * 60 * C; k++) begin
            get_cnt(v);
            check("R5 minutes count", v, 2 - k / (60 * C));
            if (k < 2 * 60 * C) step(1);
        end
        get_status(s); check("R5 minute expiry", s, 1);
        step(P + 1);

        // R10 immediate sources, enabled and disabled
        wr(I_CFG, 8'h80);
        for (int src = 0; src < 4; src++) begin
            for (int en = 0; en < 2; en++) begin
                if (src == 3 && en == 1) continue;
                wr(I_CTRL, en ? 8'(1 << (4 + src)) : 8'h00);
                wr(I_HI, 8'h00); wr(I_LO, 8'h04);
                step(4);
                pulse_ev(src);
                get_cnt(v); check("R10 after event", v, en ? 4 : 3);
                step(C);
                get_cnt(v); check("R10 one second on", v, en ? 3 : 2);
                step(en ? 8 : 3);
                get_cnt(v); check("R10 before expiry", v, 1);
                get_status(s); check("R10 not expired", s, 0);
                step(1);
                get_status(s); check("R10 expiry edge", s, 1);
            end
        end

        // R11 delayed infrared reload
        wr(I_CTRL, 8'h80); wr(I_HI, 8'h00); wr(I_LO, 8'h04);
        step(1);
        pulse_ev(3);
        step(1);
        pulse_ev(3);
        step(2);
        get_cnt(v); check("R11 before delayed reload", v, 2);
        step(1);
        get_cnt(v); check("R11 delayed reload", v, 4);
        step(11);
        get_cnt(v); check("R11 no second reload", v, 1);
        step(1);
        get_status(s); check("R11 expiry after reload", s, 1);

        // R12 events ignored when expired; R9 bit0=1 keeps status
        wr(I_CTRL, 8'h11);
        get_status(s); check("R9 write one keeps status", s, 1);
        pulse_ev(0);
        get_cnt(v); check("R12 no restart", v, 0);
        step(2 * C);
        get_cnt(v); check("R12 still stopped", v, 0);

        // R8 force while stopped, R7 pwr/tmo paths
        wr(I_CFG, 8'hB0); wr(I_CTRL, 8'h00);
        get_status(s); check("R9 clear", s, 0);
        wr(I_CTRL, 8'h01);
        get_status(s); check("R9 write one no set", s, 0);
        wr(I_CTRL, 8'h02);
        get_status(s); check("R8 force stopped", s, 1);
        check("R7 pwr pulse", int'(pwr_rst_o), 1);
        check("R7 kbd disabled", int'(kbd_rst_o), 0);
        check("R7 tmo level", int'(tmo_o), 1);
        step(P);
        check("R7 pwr pulse ends", int'(pwr_rst_o), 0);
        check("R7 tmo holds", int'(tmo_o), 1);
        wr(I_CTRL, 8'h00);
        check("R9 tmo clears", int'(tmo_o), 0);

        // R8 force while running
        wr(I_LO, 8'h09); step(2);
        wr(I_CTRL, 8'h02);
        get_cnt(v); check("R8 force running count", v, 0);
        get_status(s); check("R8 force running status", s, 1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule